// File: doc/BRIEF.md
# Exclusive Prefetch Conversion Queue

This block sits on the cache side of a load/store path. It takes requests that ask for write permission on an address, each with the tag lookup result that says whether the line is already present and writable. A request that finds a writable line is absorbed: the block counts a hit and does nothing else. Any other request is turned into a block-aligned hardware prefetch that needs exclusive permission and expects no response. That prefetch goes into a bounded FIFO together with the cycle at which it becomes ready.

The head of the FIFO is offered to the memory-side bus when two conditions hold: its own ready time has passed, and the bus-request time set by the most recent enqueue has also passed. That bus-request time is the later of the head's ready time and the new entry's ready time. A full queue never refuses a request. It discards its oldest entry, counts the drop, and appends the new one.

Both data interfaces are valid/ready. `req_ready` is held high at all times, because overflow is resolved by eviction and not by back-pressure. On the output side, `pf_valid` with its address and command is held stable until the cycle in which `pf_ready` is high. The head is popped only in that cycle. The counters and `head_time` are plain status outputs.

Top module: `xpf_queue`

## Requirements
- R1: A request with `req_wr_hit`=1 increments `hit_count` by one and changes nothing else: `queued_count`, `drop_count`, `pf_valid` and `head_time` are unaffected.
- R2: `req_ready` is always 1. A request with `req_wr_hit`=0 (a miss, or a hit without write permission) is accepted, increments `queued_count` by one, and adds one entry at the queue tail.
- R3: `pf_addr` equals the request address with its low log2(BLK_BYTES) bits cleared.
- R4: `pf_cmd` is 2'b10 whenever `pf_valid` is high. Bit 1 means exclusive permission is required; bit 0 means a response is expected, and it is 0.
- R5: The design keeps a cycle counter that starts at 0 on reset and increments on every clock edge. An entry accepted when the counter reads T gets ready time T+LAT. On an otherwise idle queue it raises `pf_valid` after LAT-1 further clock edges following the accepting edge.
- R6: When the queue holds DEPTH entries and a request is accepted without a pop in the same cycle, the oldest entry is discarded, `drop_count` increments by one, and the new entry goes to the tail. A push in the same cycle as a pop from a full queue drops nothing.
- R7: Each enqueue sets a bus-request time equal to the later of the head's ready time and the new entry's ready time. `pf_valid` stays low until the counter reaches that time, even when the head itself is already ready.
- R8: `head_time` is all ones when the queue is empty. Otherwise it is the ready time of the head entry.
- R9: The head is removed only in a cycle with `pf_valid` and `pf_ready` both high. Until then `pf_addr` is held. Entries leave in insertion order.
- R10: After reset the queue is empty, `pf_valid` is 0, all three counters are 0 and `head_time` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Store-permission request present |
| req_ready | output | 1 | Always high; the block never back-pressures |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wr_hit | input | 1 | Tag lookup found the line present and writable |
| pf_valid | output | 1 | Head prefetch offered to the memory-side bus |
| pf_ready | input | 1 | Bus grant; pops the head when `pf_valid` is high |
| pf_addr | output | ADDR_W | Block-aligned prefetch address |
| pf_cmd | output | 2 | Command bits {exclusive, response-expected} |
| head_time | output | TIME_W | Ready time of the head, all ones when empty |
| hit_count | output | CNT_W | Requests absorbed as writable hits |
| queued_count | output | CNT_W | Requests converted and enqueued |
| drop_count | output | CNT_W | Entries discarded because the queue was full |

## Verification
The embedded assertions check the invariants on every cycle. They confirm that occupancy never exceeds the depth, that an absorbed hit leaves the enqueue counter untouched, and that every enqueue raises it by one. They also check that offered addresses are block-aligned, that `pf_valid` never precedes the head's ready time, that an empty queue reports the all-ones time, and that the head holds while nothing is pushed or popped. The directed scenarios are needed for everything that depends on history. That covers the exact cycle at which a prefetch appears, the delay a later enqueue imposes on an already-ready head, which entry is evicted on overflow and in what order the survivors drain, and the absence of a drop when a push meets a pop on a full queue.

// File: rtl/xpf_pkg.sv
package xpf_pkg;
  // bit 1: exclusive permission required, bit 0: response expected
  typedef enum logic [1:0] {
    PF_CMD_NONE = 2'b00,
    PF_CMD_EXCL = 2'b10
  } pf_cmd_e;
endpackage

// File: rtl/xpf_convert.sv
module xpf_convert #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int TIME_W = 32,
  parameter int LAT    = 4
) (
  input  logic              req_valid,
  input  logic              req_wr_hit,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TIME_W-1:0] now,
  output logic              take_hit,
  output logic              take_enq,
  output logic [ADDR_W-1:0] blk_addr,
  output logic [TIME_W-1:0] ready_t
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

  always_comb begin
    take_hit = req_valid && req_wr_hit;
    take_enq = req_valid && !req_wr_hit;
    blk_addr = req_addr & ~OFF_MASK;
    ready_t  = now + TIME_W'(LAT);
  end
endmodule

// File: rtl/xpf_ring.sv
module xpf_ring #(
  parameter int DEPTH = 4,
  parameter int DW    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full,
  output logic          dropped
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] occ;
  logic          do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (occ == '0);
  assign full    = (occ == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign dropped = push && full && !do_pop;
  assign dout    = mem[head];

  always_ff @(posedge clk) begin
    if (push) mem[tail] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (push) tail <= nxt(tail);
      if (do_pop || dropped) head <= nxt(head);
      if (push && !do_pop && !dropped) occ <= occ + CW'(1);
      else if (do_pop && !push)        occ <= occ - CW'(1);
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  assert_head_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop && !push) |=> $stable(dout));
endmodule

// File: rtl/xpf_queue.sv
module xpf_queue #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int DEPTH     = 4,
  parameter int LAT       = 4,
  parameter int TIME_W    = 32,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wr_hit,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [1:0]        pf_cmd,
  output logic [TIME_W-1:0] head_time,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  queued_count,
  output logic [CNT_W-1:0]  drop_count
);
  import xpf_pkg::*;

  localparam int OFF_W = $clog2(BLK_BYTES);
  localparam int DW    = ADDR_W + TIME_W;
  localparam logic [TIME_W-1:0] NEVER = '1;

  initial assert ((1 << OFF_W) == BLK_BYTES)
    else $error("BLK_BYTES must be a power of two");

  logic [TIME_W-1:0] now, bus_at, new_t, cand_t;
  logic              take_hit, take_enq, q_empty, q_full, q_drop;
  logic [ADDR_W-1:0] blk_addr;
  logic [DW-1:0]     q_out;
  logic [TIME_W-1:0] q_time;

  xpf_convert #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .TIME_W(TIME_W), .LAT(LAT)) u_conv (
    .req_valid (req_valid),
    .req_wr_hit(req_wr_hit),
    .req_addr  (req_addr),
    .now       (now),
    .take_hit  (take_hit),
    .take_enq  (take_enq),
    .blk_addr  (blk_addr),
    .ready_t   (new_t)
  );

  xpf_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (take_enq),
    .din    ({blk_addr, new_t}),
    .pop    (pf_valid && pf_ready),
    .dout   (q_out),
    .empty  (q_empty),
    .full   (q_full),
    .dropped(q_drop)
  );

  assign q_time    = q_out[TIME_W-1:0];
  assign req_ready = 1'b1;
  assign pf_addr   = q_out[DW-1:TIME_W];
  assign pf_cmd    = pf_valid ? PF_CMD_EXCL : PF_CMD_NONE;
  assign head_time = q_empty ? NEVER : q_time;
  assign pf_valid  = !q_empty && (now >= q_time) && (now >= bus_at);

  // bus-request time: later of current head ready time and the new entry's
  assign cand_t = (!q_empty && q_time > new_t) ? q_time : new_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now          <= '0;
      bus_at       <= '0;
      hit_count    <= '0;
      queued_count <= '0;
      drop_count   <= '0;
    end else begin
      now <= now + TIME_W'(1);
      if (take_enq) begin
        bus_at       <= cand_t;
        queued_count <= queued_count + CNT_W'(1);
      end
      if (take_hit) hit_count  <= hit_count + CNT_W'(1);
      if (q_drop)   drop_count <= drop_count + CNT_W'(1);
    end
  end

  assert_hit_absorbed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wr_hit) |=> $stable(queued_count));

  assert_enqueue_counted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_wr_hit) |=> (queued_count == $past(queued_count) + CNT_W'(1)));

  assert_block_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr[OFF_W-1:0] == '0));

  assert_not_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (now >= head_time));

  assert_empty_never_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf_valid && head_time != NEVER) |-> !q_empty);
endmodule

// File: tb/xpf_queue_test.sv
module xpf_queue_test;
  localparam int LAT = 4;
  localparam int DEPTH = 4;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_wr_hit = 0, pf_ready = 0;
  logic [31:0] req_addr = 0;
  logic        req_ready, pf_valid;
  logic [31:0] pf_addr, head_time;
  logic [1:0]  pf_cmd;
  logic [15:0] hit_count, queued_count, drop_count;
  int          cyc = 0;
  int          errors = 0, checks = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  xpf_queue uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wr_hit(req_wr_hit), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_cmd(pf_cmd),
    .head_time(head_time), .hit_count(hit_count),
    .queued_count(queued_count), .drop_count(drop_count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the following negedge
  task automatic send(input logic [31:0] a, input logic wh, output int t0);
    req_valid = 1; req_addr = a; req_wr_hit = wh; t0 = cyc;
    @(posedge clk); #1;
    req_valid = 0; req_wr_hit = 0;
    @(negedge clk);
  endtask

  task automatic drain_one(input logic [31:0] exp, input string req);
    int n = 0;
    while (!pf_valid && n < 60) begin @(negedge clk); n++; end
    chk(pf_valid && pf_addr == exp, req, pf_addr, exp);
    chk(pf_cmd == 2'b10, "R4", pf_cmd, 2'b10);
    pf_ready = 1;
    @(posedge clk); #1;
    pf_ready = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(pf_valid == 0, "R10", pf_valid, 0);
    chk(hit_count == 0 && queued_count == 0 && drop_count == 0, "R10",
        {hit_count, queued_count, drop_count}, 0);
    chk(head_time == 32'hFFFF_FFFF, "R8", head_time, 32'hFFFF_FFFF);
    chk(req_ready == 1, "R2", req_ready, 1);
  endtask

  task automatic t_write_hit();
    int t0;
    send(32'h0000_1040, 1'b1, t0);
    chk(hit_count == 1, "R1", hit_count, 1);
    chk(queued_count == 0, "R1", queued_count, 0);
    for (int k = 0; k < LAT + 2; k++) begin
      chk(pf_valid == 0 && head_time == 32'hFFFF_FFFF, "R1", pf_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_single();
    int t0;
    send(32'h1234_5678, 1'b0, t0);
    chk(queued_count == 1, "R2", queued_count, 1);
    chk(head_time == 32'(t0 + LAT), "R5", head_time, t0 + LAT);
    for (int k = 1; k < LAT; k++) begin
      chk(pf_valid == 0, "R5", pf_valid, 0);
      @(negedge clk);
    end
    chk(pf_valid == 1, "R5", pf_valid, 1);
    chk(pf_addr == 32'h1234_5640, "R3", pf_addr, 32'h1234_5640);
    drain_one(32'h1234_5640, "R9");
    chk(pf_valid == 0 && head_time == 32'hFFFF_FFFF, "R8", head_time, 32'hFFFF_FFFF);
  endtask

  task automatic t_order_hold();
    int t0;
    send(32'h0000_2000, 1'b0, t0);
    send(32'h0000_30FF, 1'b0, t0);
    send(32'h0000_4001, 1'b0, t0);
    while (!pf_valid) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk(pf_addr == 32'h0000_2000, "R9", pf_addr, 32'h0000_2000);
      @(negedge clk);
    end
    drain_one(32'h0000_2000, "R9");
    drain_one(32'h0000_30C0, "R9");
    drain_one(32'h0000_4000, "R9");
  endtask

  task automatic t_overflow();
    int t0;
    logic [15:0] d0 = drop_count, q0 = queued_count;
    for (int i = 1; i <= DEPTH + 1; i++) send(32'h0001_0000 * i, 1'b0, t0);
    chk(drop_count == d0 + 1, "R6", drop_count, d0 + 1);
    chk(queued_count == q0 + DEPTH + 1, "R2", queued_count, q0 + DEPTH + 1);
    for (int i = 2; i <= DEPTH + 1; i++) drain_one(32'h0001_0000 * i, "R6");
    chk(pf_valid == 0 && head_time == 32'hFFFF_FFFF, "R8", head_time, 32'hFFFF_FFFF);
  endtask

  task automatic t_full_pushpop();
    int t0;
    logic [15:0] d0 = drop_count;
    for (int i = 1; i <= DEPTH; i++) send(32'h0020_0000 + 32'h100 * i, 1'b0, t0);
    while (!pf_valid) @(negedge clk);
    req_valid = 1; req_addr = 32'h0020_0900; pf_ready = 1;
    @(posedge clk); #1;
    req_valid = 0; pf_ready = 0;
    @(negedge clk);
    chk(drop_count == d0, "R6", drop_count, d0);
    for (int i = 2; i <= DEPTH; i++) drain_one(32'h0020_0000 + 32'h100 * i, "R6");
    drain_one(32'h0020_0900, "R6");
  endtask

  task automatic t_gate();
    int ta, tb;
    bool_ok: begin end
    send(32'h0300_0000, 1'b0, ta);
    @(negedge clk);
    send(32'h0400_0000, 1'b0, tb);
    while (cyc < tb + LAT) begin
      chk(pf_valid == 0, "R7", pf_valid, 0);
      if (cyc == ta + LAT) chk(head_time == 32'(ta + LAT), "R8", head_time, ta + LAT);
      @(negedge clk);
    end
    chk(pf_valid == 1 && pf_addr == 32'h0300_0000, "R7", pf_addr, 32'h0300_0000);
    drain_one(32'h0300_0000, "R7");
    drain_one(32'h0400_0000, "R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_hit();
    t_single();
    t_order_hold();
    t_overflow();
    t_full_pushpop();
    t_gate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule